// File: doc/BRIEF.md
# Processor power-up reset sequencer

This block brings a processor out of a cold boot. It drives two outputs toward the processor: a power-good line and an active-low reset line. Before power-good rises, the processor runs from an internal free-running oscillator. When power-good rises, the processor hands its clock over to its PLL, and the PLL then needs time to lock while reset is still held. The block watches three status inputs: one that says the main supply rails are stable, one for the PLL analog rail, and one that says the reference clock is running. Power-good rises only after each of several minimum waits has passed. Reset is released after one more long hold.

All waits are counted in cycles of a free-running sequencer clock. Each wait is given as a duration in nanoseconds and turned into a cycle count at elaboration, rounded up. Power-good never toggles within one boot. If a supply input drops at any point, the block returns to its initial condition and runs the whole sequence again from the start.

Top module: `pwrup_seq`

## Requirements
- R1: While `rst_n` is low, `pwr_good`, `cpu_rst_n` and `seq_done` are all low.
- R2: `pwr_good` rises only if `rails_ok` and `pll_rail_ok` were both high at the clock edge that raised it.
- R3: Before `pwr_good` rises, `cpu_rst_n` has been low for at least N_LEAD sequencer cycles.
- R4: Before `pwr_good` rises, `rails_ok` and `pll_rail_ok` have both been continuously high for more than N_PLL cycles.
- R5: Before `pwr_good` rises, `refclk_ok` has been continuously high for more than N_REF cycles. A low cycle on `refclk_ok` before that point restarts this wait, and while it stays low `pwr_good` stays low.
- R6: Once `pwr_good` has risen, `cpu_rst_n` stays low for exactly N_LOCK cycles and then goes high, as long as no supply drops. A drop of `refclk_ok` during this hold has no effect.
- R7: `pwr_good` is monotonic: it falls only at a clock edge where a supply input (`rails_ok` or `pll_rail_ok`) was low.
- R8: A low on `rails_ok` or `pll_rail_ok` in any state forces `pwr_good`, `cpu_rst_n` and `seq_done` low after that clock edge. All waits then restart from zero.
- R9: `seq_done` rises in the same cycle as `cpu_rst_n` and stays high until a supply drop or `rst_n`.
- R10: Each count is ceil(T_ns / CLK_PERIOD_NS), with a minimum of 1. The timing is cycle-exact: in the HOLD phase, `pwr_good` rises at the first edge where all three waits are met and the supplies and `refclk_ok` are high. With an 8 ns clock and waits of 10/40/100/120 ns, the counts are 2/5/13/15. With all inputs high from the release of `rst_n`, `pwr_good` rises at the 14th edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running sequencer clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset of the sequencer |
| rails_ok | input | 1 | Main supply rails are stable |
| pll_rail_ok | input | 1 | PLL analog rail is stable |
| refclk_ok | input | 1 | Reference system clock is running |
| pwr_good | output | 1 | Power-good to the processor, registered |
| cpu_rst_n | output | 1 | Active-low processor reset, registered |
| seq_done | output | 1 | Boot sequence complete, reset released |

## Verification
The bench goes after several corner cases.

- **Supply dropouts in each phase.** It removes a supply in the waiting phase, in the lock hold and after release. A design that only stretched one reset pulse would keep power-good high through the drop, or raise it again too soon, which would break monotonicity or cut the lead interval short.
- **One-cycle reference-clock glitch.** This glitch comes just before the clock wait would finish. A counter that does not clear on the glitch raises power-good early.
- **Clock loss during the lock hold.** The clock is lost while reset is held after power-good. A design that reacts to it drops power-good.
- **Release of reset.** The bench measures the exact cycle of release, which exposes an off-by-one in the lock counter.
- **Rounding of the cycle counts.** A 100 ns wait at 8 ns per cycle must become 13 cycles. Truncation gives 12, and power-good rises one cycle early.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    PS_HOLD = 2'd0,
    PS_LOCK = 2'd1,
    PS_RUN  = 2'd2
  } pwrup_state_e;

  localparam int unsigned NUM_WAITS = 3;
  localparam int unsigned W_LEAD    = 0;
  localparam int unsigned W_PLL     = 1;
  localparam int unsigned W_REF     = 2;

  // Round a duration up to whole clock periods, never below one cycle.
  function automatic int unsigned ns_to_cycles(input int unsigned t_ns,
                                               input int unsigned per_ns);
    int unsigned c;
    c = (t_ns + per_ns - 1) / per_ns;
    return (c == 0) ? 1 : c;
  endfunction

  // Counter width that can hold the value lim.
  function automatic int unsigned ctr_width(input int unsigned lim);
    return (lim < 2) ? 1 : $clog2(lim + 1);
  endfunction

endpackage

// File: rtl/pwrup_sat_ctr.sv
module pwrup_sat_ctr #(
  parameter int unsigned LIMIT = 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  output logic expired
);
  localparam int unsigned W = pwrup_pkg::ctr_width(LIMIT);
  localparam logic [W-1:0] TOP = W'(LIMIT);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (clr)        cnt <= '0;
    else if (cnt != TOP) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt == TOP);
endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
  import pwrup_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         supply_ok,
  input  logic         refclk_ok,
  input  logic         waits_met,
  input  logic         lock_met,
  output pwrup_state_e state,
  output pwrup_state_e state_nxt,
  output logic         launch_evt,
  output logic         release_evt,
  output logic         restart_evt
);
  always_comb begin
    state_nxt = state;
    unique case (state)
      PS_HOLD: if (supply_ok && refclk_ok && waits_met) state_nxt = PS_LOCK;
      PS_LOCK: begin
        if (!supply_ok)    state_nxt = PS_HOLD;
        else if (lock_met) state_nxt = PS_RUN;
      end
      PS_RUN:  if (!supply_ok) state_nxt = PS_HOLD;
      default: state_nxt = PS_HOLD;
    endcase
  end

  assign launch_evt  = (state == PS_HOLD) && (state_nxt == PS_LOCK);
  assign release_evt = (state == PS_LOCK) && (state_nxt == PS_RUN);
  assign restart_evt = (state != PS_HOLD) && !supply_ok;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= PS_HOLD;
    else        state <= state_nxt;
  end
endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
  import pwrup_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS = 8,
  parameter int unsigned T_LEAD_NS     = 10,
  parameter int unsigned T_PLL_NS      = 5000,
  parameter int unsigned T_REF_NS      = 3000000,
  parameter int unsigned T_LOCK_NS     = 1500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rails_ok,
  input  logic pll_rail_ok,
  input  logic refclk_ok,
  output logic pwr_good,
  output logic cpu_rst_n,
  output logic seq_done
);
  localparam int unsigned N_LEAD = ns_to_cycles(T_LEAD_NS, CLK_PERIOD_NS);
  localparam int unsigned N_PLL  = ns_to_cycles(T_PLL_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_REF  = ns_to_cycles(T_REF_NS,  CLK_PERIOD_NS);
  localparam int unsigned N_LOCK = ns_to_cycles(T_LOCK_NS, CLK_PERIOD_NS);
  localparam int unsigned WAIT_LIM [NUM_WAITS] = '{N_LEAD, N_PLL, N_REF};

  pwrup_state_e state, state_nxt;
  logic supply_ok, in_hold;
  logic waits_met, lock_met;
  logic launch_evt, release_evt, restart_evt;
  logic [NUM_WAITS-1:0] wait_clr, wait_exp;

  assign supply_ok = rails_ok && pll_rail_ok;
  assign in_hold   = (state == PS_HOLD);

  // Each wait restarts whenever its own condition is lost or the phase is left.
  assign wait_clr[W_LEAD] = !in_hold;
  assign wait_clr[W_PLL]  = !in_hold || !supply_ok;
  assign wait_clr[W_REF]  = !in_hold || !refclk_ok;

  for (genvar g = 0; g < NUM_WAITS; g++) begin : g_wait
    pwrup_sat_ctr #(.LIMIT(WAIT_LIM[g])) u_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (wait_clr[g]),
      .expired (wait_exp[g])
    );
  end

  assign waits_met = &wait_exp;

  pwrup_sat_ctr #(.LIMIT(N_LOCK - 1)) u_lock_ctr (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (state != PS_LOCK),
    .expired (lock_met)
  );

  pwrup_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n),
    .supply_ok   (supply_ok),
    .refclk_ok   (refclk_ok),
    .waits_met   (waits_met),
    .lock_met    (lock_met),
    .state       (state),
    .state_nxt   (state_nxt),
    .launch_evt  (launch_evt),
    .release_evt (release_evt),
    .restart_evt (restart_evt)
  );

  // Dedicated output flops, so the processor pins never see decode glitches.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pwr_good  <= 1'b0;
      cpu_rst_n <= 1'b0;
      seq_done  <= 1'b0;
    end else begin
      pwr_good  <= (state_nxt != PS_HOLD);
      cpu_rst_n <= (state_nxt == PS_RUN);
      seq_done  <= (state_nxt == PS_RUN);
    end
  end
endmodule

// File: rtl/pwrup_seq_chk.sv
module pwrup_seq_chk #(
  parameter int unsigned N_LEAD = 1,
  parameter int unsigned N_PLL  = 1,
  parameter int unsigned N_REF  = 1,
  parameter int unsigned N_LOCK = 1
) (
  input logic clk,
  input logic rst_n,
  input logic rails_ok,
  input logic pll_rail_ok,
  input logic refclk_ok,
  input logic pwr_good,
  input logic cpu_rst_n,
  input logic seq_done,
  input logic launch_evt,
  input logic release_evt,
  input logic restart_evt
);
  int unsigned rst_low_run, pll_run, ref_run, lock_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_low_run <= 0;
      pll_run     <= 0;
      ref_run     <= 0;
      lock_run    <= 0;
    end else begin
      rst_low_run <= !cpu_rst_n ? rst_low_run + 1 : 0;
      pll_run     <= (rails_ok && pll_rail_ok) ? pll_run + 1 : 0;
      ref_run     <= refclk_ok ? ref_run + 1 : 0;
      lock_run    <= (pwr_good && !cpu_rst_n) ? lock_run + 1 : 0;
    end
  end

  always @(posedge clk) begin
    if (!rst_n) begin
      assert_reset_outputs_R1: assert (!pwr_good && !cpu_rst_n && !seq_done);
    end
  end

  assert_supplies_at_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> $past(rails_ok && pll_rail_ok));

  assert_launch_raises_pg_R2: assert property (@(posedge clk) disable iff (!rst_n)
    launch_evt |=> $rose(pwr_good));

  assert_reset_lead_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> (!cpu_rst_n && rst_low_run >= N_LEAD));

  assert_pll_rail_settle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> (pll_run > N_PLL));

  assert_refclk_settle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_good) |-> (ref_run > N_REF));

  assert_lock_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_rst_n) |-> (lock_run == N_LOCK));

  assert_release_event_R6: assert property (@(posedge clk) disable iff (!rst_n)
    release_evt |=> $rose(cpu_rst_n));

  assert_pg_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pwr_good) |-> $past(!(rails_ok && pll_rail_ok)));

  assert_fault_restart_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(rails_ok && pll_rail_ok) |=> (!pwr_good && !cpu_rst_n && !seq_done));

  assert_restart_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_evt |=> $fell(pwr_good));

  assert_done_with_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(seq_done) |-> ($rose(cpu_rst_n) && pwr_good));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(seq_done) |-> $past(!(rails_ok && pll_rail_ok)));
endmodule

bind pwrup_seq pwrup_seq_chk #(
  .N_LEAD (N_LEAD),
  .N_PLL  (N_PLL),
  .N_REF  (N_REF),
  .N_LOCK (N_LOCK)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .rails_ok    (rails_ok),
  .pll_rail_ok (pll_rail_ok),
  .refclk_ok   (refclk_ok),
  .pwr_good    (pwr_good),
  .cpu_rst_n   (cpu_rst_n),
  .seq_done    (seq_done),
  .launch_evt  (launch_evt),
  .release_evt (release_evt),
  .restart_evt (restart_evt)
);

// File: tb/pwrup_seq_tb.sv
module pwrup_seq_tb;
  localparam int PER = 8;
  localparam int TL = 10, TP = 40, TR = 100, TK = 120;

  // Bench-side rounding: whole periods plus one if any remainder is left.
  function automatic int up(input int t);
    int c;
    c = t / PER + (((t % PER) != 0) ? 1 : 0);
    return (c < 1) ? 1 : c;
  endfunction
  localparam int NL = up(TL), NP = up(TP), NR = up(TR), NK = up(TK);

  logic clk = 1'b0;
  logic rst_n = 1'b0, rails_ok = 1'b0, pll_rail_ok = 1'b0, refclk_ok = 1'b0;
  logic pwr_good, cpu_rst_n, seq_done;

  always #4 clk = ~clk;

  pwrup_seq #(.CLK_PERIOD_NS(PER), .T_LEAD_NS(TL), .T_PLL_NS(TP),
              .T_REF_NS(TR), .T_LOCK_NS(TK)) u_dut (
    .clk(clk), .rst_n(rst_n), .rails_ok(rails_ok), .pll_rail_ok(pll_rail_ok),
    .refclk_ok(refclk_ok), .pwr_good(pwr_good), .cpu_rst_n(cpu_rst_n),
    .seq_done(seq_done));

  int checks = 0, failures = 0;
  bit reported = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    end
  endtask

  // Behavioural reference: phase 0 waiting, 1 holding reset after power-good, 2 released.
  int m_phase = 0, a_lead = 0, a_pll = 0, a_ref = 0, a_lock = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; a_lead = 0; a_pll = 0; a_ref = 0; a_lock = 0;
    end else if (m_phase != 0 && !(rails_ok && pll_rail_ok)) begin
      m_phase = 0; a_lead = 0; a_pll = 0; a_ref = 0;
    end else if (m_phase == 0) begin
      if (rails_ok && pll_rail_ok && refclk_ok &&
          a_lead >= NL && a_pll >= NP && a_ref >= NR) begin
        m_phase = 1; a_lock = 0; a_lead = 0; a_pll = 0; a_ref = 0;
      end else begin
        a_lead++;
        a_pll = (rails_ok && pll_rail_ok) ? a_pll + 1 : 0;
        a_ref = refclk_ok ? a_ref + 1 : 0;
      end
    end else if (m_phase == 1) begin
      if (a_lock == NK - 1) m_phase = 2;
      else a_lock++;
    end
  end

  // Per-cycle comparison and interval monitors, sampled away from the active edge.
  int r_rstlow = 0, r_pll = 0, r_ref = 0, r_lock = 0;
  logic p_pg = 0, p_rst = 0;
  always @(negedge clk) begin
    bit sup;
    sup = rails_ok && pll_rail_ok;
    chk(pwr_good == (m_phase >= 1), "R2", "pwr_good vs model", pwr_good, m_phase >= 1);
    chk(cpu_rst_n == (m_phase == 2), "R6", "cpu_rst_n vs model", cpu_rst_n, m_phase == 2);
    chk(seq_done == (m_phase == 2), "R9", "seq_done vs model", seq_done, m_phase == 2);
    r_pll = sup ? r_pll + 1 : 0;
    r_ref = refclk_ok ? r_ref + 1 : 0;
    if (!rst_n)
      chk(!pwr_good && !cpu_rst_n && !seq_done, "R1", "outputs in reset",
          {pwr_good, cpu_rst_n, seq_done}, 0);
    else begin
      if (!sup)
        chk(!pwr_good && !cpu_rst_n && !seq_done, "R8", "outputs after supply drop",
            {pwr_good, cpu_rst_n, seq_done}, 0);
      if (pwr_good && !p_pg) begin
        chk(r_rstlow >= NL, "R3", "reset-low cycles before power-good", r_rstlow, NL);
        chk(r_pll >= NP + 1, "R4", "supply-stable cycles before power-good", r_pll, NP + 1);
        chk(r_ref >= NR + 1, "R5", "refclk cycles before power-good", r_ref, NR + 1);
      end
      if (!pwr_good && p_pg)
        chk(!sup, "R7", "power-good fell without supply drop", sup, 0);
      if (cpu_rst_n && !p_rst)
        chk(r_lock == NK, "R6", "lock hold cycles", r_lock, NK);
    end
    r_rstlow = !cpu_rst_n ? r_rstlow + 1 : 0;
    r_lock = (pwr_good && !cpu_rst_n) ? r_lock + 1 : 0;
    p_pg = pwr_good;
    p_rst = cpu_rst_n;
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic run_to_done(input int lim);
    for (int i = 0; i < lim && !seq_done; i++) step(1);
    chk(seq_done && cpu_rst_n && pwr_good, "R9", "sequence completes",
        {pwr_good, cpu_rst_n, seq_done}, 7);
  endtask

  task automatic run_to_pg(input int lim);
    for (int i = 0; i < lim && !pwr_good; i++) step(1);
  endtask

  initial begin
    int n;
    step(5);
    chk(!pwr_good && !cpu_rst_n && !seq_done, "R1", "reset state",
        {pwr_good, cpu_rst_n, seq_done}, 0);
    chk(NL == 2 && NP == 5 && NR == 13 && NK == 15, "R10", "rounded counts",
        NL * 1000000 + NP * 10000 + NR * 100 + NK, 2051315);

    // All inputs high at release: rise after the longest wait plus one edge.
    rst_n = 1; rails_ok = 1; pll_rail_ok = 1; refclk_ok = 1;
    n = 0;
    do begin @(negedge clk); n++; end while (!pwr_good && n < 100);
    chk(n == NR + 1, "R10", "cycles to power-good", n, NR + 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!cpu_rst_n && n < 100);
    chk(n == NK, "R6", "cycles power-good to release", n, NK);
    #1;
    step(4);
    chk(seq_done == 1, "R9", "done holds", seq_done, 1);

    // Supply drop after release.
    rails_ok = 0; step(1);
    chk(!pwr_good && !seq_done, "R8", "drop in run", {pwr_good, seq_done}, 0);
    step(1); rails_ok = 1;
    run_to_done(80);

    // PLL-rail drop during the lock hold.
    rails_ok = 0; step(1); rails_ok = 1;
    run_to_pg(60); step(3);
    pll_rail_ok = 0; step(1);
    chk(pwr_good == 0, "R8", "drop in lock hold", pwr_good, 0);
    pll_rail_ok = 1;
    run_to_done(80);

    // Drop during the waiting phase, partway through the PLL wait.
    rails_ok = 0; step(1); rails_ok = 1; step(3);
    pll_rail_ok = 0; step(1); pll_rail_ok = 1;
    run_to_done(80);

    // One-cycle reference-clock glitch just before its wait expires.
    rails_ok = 0; step(1); rails_ok = 1; step(NR - 2);
    refclk_ok = 0; step(1); refclk_ok = 1;
    step(NR);
    chk(pwr_good == 0, "R5", "glitch restarts clock wait", pwr_good, 0);
    run_to_done(80);

    // Reference clock absent: power-good must stay low.
    rails_ok = 0; refclk_ok = 0; step(1); rails_ok = 1;
    step(3 * NR);
    chk(pwr_good == 0, "R5", "no power-good without refclk", pwr_good, 0);
    refclk_ok = 1;
    run_to_done(80);

    // Reference clock lost during the lock hold is ignored.
    rails_ok = 0; step(1); rails_ok = 1;
    run_to_pg(60); step(2);
    refclk_ok = 0; step(3);
    chk(pwr_good == 1, "R6", "refclk loss in lock hold ignored", pwr_good, 1);
    refclk_ok = 1;
    run_to_done(80);

    // Staggered arrival: refclk first, PLL rail last.
    rst_n = 0; rails_ok = 0; pll_rail_ok = 0; refclk_ok = 0; step(2);
    chk(!pwr_good && !cpu_rst_n, "R1", "reset mid-run", {pwr_good, cpu_rst_n}, 0);
    rst_n = 1; refclk_ok = 1; step(4); rails_ok = 1; step(6); pll_rail_ok = 1;
    run_to_done(80);

    step(5);
    report();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    report();
    $finish;
  end
endmodule